// File: doc/BRIEF.md
# Energy-to-Pulse Output Generator

This block turns a stream of signed energy increments into output pulses. Each time `sample_valid` is high, the increment on `sample_inc` is added to a signed running total. While the total is at or beyond one pulse's worth of energy (`pulse_energy`) in either direction, the block issues one pulse and takes one pulse's worth off the total. One large sample can therefore produce a burst of pulses. After the burst the outputs rest until further energy arrives. The leftover part of the total is always smaller than one pulse. It is kept and combined with later increments, so no energy is lost across sample periods.

The mode inputs pick one of two output formats. In the normal format, `out_pulse` goes high for `spacing` clock cycles for every pulse. `out_dir` is high for the length of a pulse that represents negative energy. In the counter format, pulses are active-low and `2**MECH_LOG2` clock cycles wide, which suits electromechanical counters. Positive energy pulses `out_pulse` and negative energy pulses `out_dir`. When the block is clocked at the divided master clock, the default width of 524288 cycles gives 128 ms at 4.096 MHz, and the width scales with the clock.

The control state machine has three states:
- `ST_IDLE`: no pulse is running.
- `ST_ACTIVE`: a pulse is on the pins.
- `ST_GAP`: an enforced inactive interval that lasts as long as a pulse.

Its transitions are:
- IDLE→ACTIVE on a pulse owed.
- ACTIVE→GAP when the width timer expires.
- GAP→ACTIVE when the gap expires with a pulse still owed.
- GAP→IDLE when the gap expires with nothing owed.

Top module: `energy_pulse_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the accumulated energy and returns the state machine to ST_IDLE. Pins then rest inactive: both low in normal format, both high in counter format.
- R2: Each cycle with `sample_valid` high adds the sign-extended `sample_inc` to the accumulator. Pulses are then issued until the accumulator magnitude is below `pulse_energy`.
- R3: The leftover energy, smaller in magnitude than one pulse, is retained and combined with later increments. The total pulse count after any sequence of samples equals the running sum divided by `pulse_energy`, truncated toward zero.
- R4: With `pulse_energy` equal to 0 no pulse is issued, but increments still accumulate. A later nonzero `pulse_energy` releases the owed pulses.
- R5: Counter format applies when `mode_mech`=1 and `mode_step`=0. Pulses are active-low and exactly 2**MECH_LOG2 cycles long. Positive energy drives `out_pulse` low and negative energy drives `out_dir` low, never both at once.
- R6: Between two pulses the pins stay inactive for at least one pulse length. Pulses owed during a running pulse are deferred, and the accumulator is reduced only when a pulse starts.
- R7: In normal format each pulse holds `out_pulse` high for `spacing` cycles (0 counts as 1). `out_dir` is high during a negative pulse, low during a positive one and low when idle.
- R8: When the block is idle, a sample that leaves a pulse owed is received at clock edge t, and the first pulse appears on the pins right after edge t+1.
- R9: With `mode_step`=1 the normal format is used regardless of `mode_mech`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (the divided master clock) |
| rst | input | 1 | Synchronous reset, active high |
| sample_valid | input | 1 | Qualifies `sample_inc` for one cycle per sample period |
| sample_inc | input | INC_W | Signed energy increment |
| pulse_energy | input | THR_W | Unsigned energy per output pulse |
| spacing | input | SP_W | Normal-format pulse length and gap in cycles |
| mode_mech | input | 1 | Selects the counter format (with `mode_step` low) |
| mode_step | input | 1 | Forces the normal format when high |
| out_pulse | output | 1 | Pulse output (positive energy in counter format) |
| out_dir | output | 1 | Direction in normal format; negative pulses in counter format |

## Verification
The hardest situation to reach is a long deferred burst: many pulses owed from one sample, each of which must wait for the previous pulse and its gap. Only then may the accumulator be reduced. The bench reaches it with threshold 1 and increments up to ±40. It measures every pulse length and gap on the pins in all four mode settings. A zero threshold followed by a nonzero one checks that the energy held back was retained. A reset issued in the middle of a burst checks that the rest of the burst is cancelled.

// File: rtl/ep_pkg.sv
package ep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_GAP    = 2'd2
    } ep_state_e;
endpackage

// File: rtl/ep_accum.sv
module ep_accum #(
    parameter int INC_W = 16,
    parameter int THR_W = 16,
    parameter int ACC_W = 20
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    add_en,
    input  logic [INC_W-1:0]        inc,
    input  logic [THR_W-1:0]        thr,
    input  logic                    take,
    input  logic                    take_neg,
    output logic                    owe_pos,
    output logic                    owe_neg,
    output logic signed [ACC_W-1:0] acc
);
    logic signed [ACC_W-1:0] inc_x;
    logic signed [ACC_W-1:0] thr_x;
    logic signed [ACC_W-1:0] delta;
    logic signed [ACC_W-1:0] acc_nx;

    always_comb begin
        inc_x = {{(ACC_W-INC_W){inc[INC_W-1]}}, inc};
        thr_x = {{(ACC_W-THR_W){1'b0}}, thr};
        if (take)
            delta = take_neg ? thr_x : -thr_x;
        else
            delta = '0;
        acc_nx = acc + (add_en ? inc_x : '0) + delta;
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else
            acc <= acc_nx;
    end

    assign owe_pos = (thr != '0) && (acc >= thr_x);
    assign owe_neg = (thr != '0) && (acc <= -thr_x);
endmodule

// File: rtl/ep_timer.sv
module ep_timer #(
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/ep_fsm.sv
module ep_fsm
    import ep_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      owe_pos,
    input  logic      owe_neg,
    input  logic      tmr_done,
    input  logic      mech_sel,
    output ep_state_e state,
    output logic      fire,
    output logic      fire_neg,
    output logic      load,
    output logic      out_pulse,
    output logic      out_dir
);
    ep_state_e state_nx;
    logic      neg_q;
    logic      owe;

    assign owe      = owe_pos | owe_neg;
    assign fire_neg = owe_neg & ~owe_pos;

    always_comb begin
        state_nx = state;
        fire     = 1'b0;
        load     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (owe) begin
                    fire     = 1'b1;
                    load     = 1'b1;
                    state_nx = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (tmr_done) begin
                    load     = 1'b1;
                    state_nx = ST_GAP;
                end
            end
            ST_GAP: begin
                if (tmr_done) begin
                    if (owe) begin
                        fire     = 1'b1;
                        load     = 1'b1;
                        state_nx = ST_ACTIVE;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            neg_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (fire)
                neg_q <= fire_neg;
        end
    end

    always_comb begin
        logic act;
        act = (state == ST_ACTIVE);
        if (mech_sel) begin
            out_pulse = ~(act & ~neg_q);
            out_dir   = ~(act & neg_q);
        end else begin
            out_pulse = act;
            out_dir   = act & neg_q;
        end
    end
endmodule

// File: rtl/energy_pulse_gen.sv
module energy_pulse_gen
    import ep_pkg::*;
#(
    parameter int INC_W     = 16,
    parameter int THR_W     = 16,
    parameter int SP_W      = 8,
    parameter int MECH_LOG2 = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_valid,
    input  logic [INC_W-1:0] sample_inc,
    input  logic [THR_W-1:0] pulse_energy,
    input  logic [SP_W-1:0]  spacing,
    input  logic             mode_mech,
    input  logic             mode_step,
    output logic             out_pulse,
    output logic             out_dir
);
    localparam int ACC_W = ((INC_W > THR_W + 1) ? INC_W : THR_W + 1) + 3;
    localparam int CNT_W = (MECH_LOG2 > SP_W) ? MECH_LOG2 : SP_W;
    localparam logic [CNT_W-1:0] MECH_M1 = CNT_W'((64'd1 << MECH_LOG2) - 64'd1);

    logic                    mech_sel;
    logic                    owe_pos;
    logic                    owe_neg;
    logic                    fire;
    logic                    fire_neg;
    logic                    load;
    logic                    tmr_done;
    logic [CNT_W-1:0]        len_m1;
    logic signed [ACC_W-1:0] acc_q;
    ep_state_e               state;

    assign mech_sel = mode_mech & ~mode_step;

    always_comb begin
        if (mech_sel)
            len_m1 = MECH_M1;
        else if (spacing == '0)
            len_m1 = '0;
        else
            len_m1 = CNT_W'(spacing) - 1'b1;
    end

    ep_accum #(
        .INC_W(INC_W),
        .THR_W(THR_W),
        .ACC_W(ACC_W)
    ) u_accum (
        .clk      (clk),
        .rst      (rst),
        .add_en   (sample_valid),
        .inc      (sample_inc),
        .thr      (pulse_energy),
        .take     (fire),
        .take_neg (fire_neg),
        .owe_pos  (owe_pos),
        .owe_neg  (owe_neg),
        .acc      (acc_q)
    );

    ep_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (len_m1),
        .done     (tmr_done)
    );

    ep_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .owe_pos   (owe_pos),
        .owe_neg   (owe_neg),
        .tmr_done  (tmr_done),
        .mech_sel  (mech_sel),
        .state     (state),
        .fire      (fire),
        .fire_neg  (fire_neg),
        .load      (load),
        .out_pulse (out_pulse),
        .out_dir   (out_dir)
    );
endmodule

// File: rtl/ep_checker.sv
module ep_checker
    import ep_pkg::*;
#(
    parameter int THR_W = 16,
    parameter int ACC_W = 20
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sample_valid,
    input  logic [THR_W-1:0]        thr,
    input  logic                    mode_mech,
    input  logic                    mode_step,
    input  logic                    out_pulse,
    input  logic                    out_dir,
    input  logic signed [ACC_W-1:0] acc,
    input  ep_state_e               st
);
    logic                    mech;
    logic signed [ACC_W-1:0] mag;
    logic signed [ACC_W-1:0] thr_x;

    assign mech  = mode_mech & ~mode_step;
    assign mag   = acc[ACC_W-1] ? -acc : acc;
    assign thr_x = {{(ACC_W-THR_W){1'b0}}, thr};

    // R1: pins idle and accumulator empty after reset
    assert_idle_after_reset_R1: assert property (@(posedge clk)
        rst |=> (acc == '0) && (mech ? (out_pulse && out_dir) : (!out_pulse && !out_dir)));

    // R5: counter format never drives both pins low
    assert_one_pin_low_R5: assert property (@(posedge clk) disable iff (rst)
        mech |-> (out_pulse || out_dir));

    // R7: normal format direction only during a pulse
    assert_dir_with_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (!mech && out_dir) |-> out_pulse);

    // R7: direction steady within one normal pulse
    assert_dir_steady_R7: assert property (@(posedge clk) disable iff (rst)
        (!mech && $stable(mech) && out_pulse && $past(out_pulse) && st == ST_ACTIVE
         && $past(st) == ST_ACTIVE) |-> $stable(out_dir));

    // R3: at rest the residual is below one pulse
    assert_residual_below_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && $past(st) == ST_IDLE && !$past(sample_valid)
         && $stable(thr) && thr != '0) |-> (mag < thr_x));
endmodule

bind energy_pulse_gen ep_checker #(
    .THR_W(THR_W),
    .ACC_W(ACC_W)
) u_ep_checker (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (sample_valid),
    .thr          (pulse_energy),
    .mode_mech    (mode_mech),
    .mode_step    (mode_step),
    .out_pulse    (out_pulse),
    .out_dir      (out_dir),
    .acc          (acc_q),
    .st           (state)
);

// File: tb/test_energy_pulse_gen.sv
`timescale 1ns/1ps
module test_energy_pulse_gen;
    localparam int CLK_PERIOD = 10;
    localparam int INC_W = 8;
    localparam int THR_W = 6;
    localparam int SP_W  = 3;
    localparam int MLOG  = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sample_valid = 1'b0;
    logic [INC_W-1:0] sample_inc = '0;
    logic [THR_W-1:0] pulse_energy = '0;
    logic [SP_W-1:0]  spacing = '0;
    logic             mode_mech = 1'b0;
    logic             mode_step = 1'b0;
    logic             out_pulse;
    logic             out_dir;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int len_b = 1;
    int pos_cnt = 0;
    int neg_cnt = 0;
    int run_len = 0;
    int gap_len = 1000;
    int first_cyc = -1;
    bit prev_act = 1'b0;
    bit arm_first = 1'b0;
    int acc_m = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    energy_pulse_gen #(
        .INC_W(INC_W), .THR_W(THR_W), .SP_W(SP_W), .MECH_LOG2(MLOG)
    ) i_energy_pulse_gen (
        .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_inc(sample_inc),
        .pulse_energy(pulse_energy), .spacing(spacing), .mode_mech(mode_mech),
        .mode_step(mode_step), .out_pulse(out_pulse), .out_dir(out_dir)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // pin monitor, sampled at the falling edge
    always @(negedge clk) begin
        bit mech, pos_a, neg_a, act;
        cyc++;
        mech  = mode_mech && !mode_step;
        pos_a = mech ? !out_pulse : (out_pulse && !out_dir);
        neg_a = mech ? !out_dir   : (out_pulse && out_dir);
        act   = pos_a || neg_a;
        if (rst) begin
            prev_act = 1'b0; run_len = 0; gap_len = 1000;
        end else begin
            if (mech)
                check(!(pos_a && neg_a), "R5 both pins low", 1, 0);
            if (act && !prev_act) begin
                check(gap_len >= len_b, "R6 gap", gap_len, len_b);
                if (pos_a) pos_cnt++; else neg_cnt++;
                if (arm_first) begin first_cyc = cyc; arm_first = 1'b0; end
                run_len = 1;
            end else if (act) begin
                run_len++;
            end else if (prev_act) begin
                check(run_len == len_b, mech ? "R5 width" : "R7 width", run_len, len_b);
                gap_len = 1;
            end else begin
                gap_len++;
            end
            prev_act = act;
        end
    end

    task automatic set_mode(input int m);
        @(posedge clk); #1;
        case (m)
            0: begin mode_mech = 0; mode_step = 0; spacing = 3'd0; len_b = 1; end
            1: begin mode_mech = 0; mode_step = 0; spacing = 3'd3; len_b = 3; end
            2: begin mode_mech = 1; mode_step = 0; spacing = 3'd5; len_b = 1 << MLOG; end
            default: begin mode_mech = 1; mode_step = 1; spacing = 3'd2; len_b = 2; end
        endcase
    endtask

    task automatic do_reset();
        @(posedge clk); #1; rst = 1'b1;
        @(posedge clk); #1; rst = 1'b0;
        acc_m = 0;
    endtask

    task automatic do_sample(input int inc, input int thr, input string tag);
        int p0, n0, n, issue, ep, en;
        p0 = pos_cnt; n0 = neg_cnt;
        @(posedge clk); #1;
        pulse_energy = THR_W'(thr);
        sample_inc = INC_W'(inc); sample_valid = 1'b1;
        issue = cyc; first_cyc = -1; arm_first = 1'b1;
        @(posedge clk); #1; sample_valid = 1'b0;
        acc_m += inc;
        n = (thr == 0) ? 0 : acc_m / thr;
        acc_m -= n * thr;
        ep = (n > 0) ? n : 0; en = (n < 0) ? -n : 0;
        repeat ((ep + en) * 2 * len_b + 8) @(posedge clk);
        arm_first = 1'b0;
        check(pos_cnt - p0 == ep, {tag, " positive count"}, pos_cnt - p0, ep);
        check(neg_cnt - n0 == en, {tag, " negative count"}, neg_cnt - n0, en);
        if (n != 0)
            check(first_cyc == issue + 3, "R8 first pulse latency", first_cyc - issue, 3);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        int incs[6] = '{5, -3, 17, -40, 2, 0};
        int thrs[3] = '{1, 4, 9};
        repeat (3) @(posedge clk);
        #1;
        check(out_pulse == 0 && out_dir == 0, "R1 reset normal pins", {out_pulse, out_dir}, 0);
        mode_mech = 1'b1; #1;
        check(out_pulse == 1 && out_dir == 1, "R1 reset counter pins", {out_pulse, out_dir}, 3);
        mode_mech = 1'b0;
        do_reset();

        for (int m = 0; m < 4; m++) begin
            set_mode(m);
            do_reset();
            for (int t = 0; t < 3; t++) begin
                for (int k = 0; k < 6; k++)
                    do_sample(incs[k], thrs[t],
                              m == 3 ? "R9" : (k == 0 ? "R2" : "R3"));
            end
        end

        // R4: zero threshold holds energy back, later release
        set_mode(1);
        do_reset();
        do_sample(50, 0, "R4 zero threshold");
        begin
            int p0;
            p0 = pos_cnt;
            @(posedge clk); #1; pulse_energy = 6'd10;
            repeat (5 * 2 * len_b + 8) @(posedge clk);
            check(pos_cnt - p0 == 5, "R4 released pulses", pos_cnt - p0, 5);
        end

        // R1: reset in the middle of a burst
        set_mode(0);
        do_reset();
        begin
            int p0;
            @(posedge clk); #1;
            pulse_energy = 6'd1; sample_inc = 8'd60; sample_valid = 1'b1;
            @(posedge clk); #1; sample_valid = 1'b0;
            repeat (12) @(posedge clk);
            do_reset();
            p0 = pos_cnt;
            repeat (200) @(posedge clk);
            check(pos_cnt == p0, "R1 burst cancelled", pos_cnt - p0, 0);
            do_sample(3, 1, "R1 cleared accumulator");
        end

        done = 1'b1;
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual 1 expected 0");
            finish_run();
        end
    end
endmodule